// File: doc/BRIEF.md
# Memory Bank Steering Predictor

This block sits beside a data cache that is split into a fast bank and a slow, low-energy bank. For every load or store it guesses, from the instruction address alone, which of the two banks holds the data, so that the access can be sent to one bank as soon as the instruction is decoded. The guess comes from a table of one-bit entries indexed by the instruction address, and it is available in the same cycle the address is presented.

When the access completes, the tags of both banks have been checked, so the bank that actually held the line is known. The block is told the instruction address, whether the line was found in either bank, and which bank it was. If the stored guess was wrong, the block raises a one-cycle mis-steer pulse so that the access can be replayed to the other bank. It then rewrites the entry with the bank that was actually hit. Each instruction is therefore steered to wherever it last found its data. Two running counts, one of resolved hits and one of mis-steers, let the caller measure accuracy.

Top module: `bank_steer_pred`

## Requirements
- R1: The table has 2^IDX_W one-bit entries (default 4096), indexed by instruction address bits [13:2]. Two addresses that differ only in bits [1:0] or in bits above 13 share one entry.
- R2: `predHot` is a combinational function of `lookupPc` and shows the addressed entry in the same cycle, with no register on the path. A value of 1 means the fast (hot) bank and 0 means the slow (cold) bank.
- R3: While reset is asserted and after it is released, every entry reads 1 (hot), `misSteer` is 0 and both counts are 0.
- R4: A resolve with `resolveValid`=1 and `resolveHit`=1 writes `resolveHot` into the entry of `resolvePc` at that clock edge. A lookup of the same entry in the next cycle shows the new value.
- R5: `misSteer` is 1 for exactly the one cycle after a hit resolve whose stored entry differed from `resolveHot`. It is 0 in every other cycle.
- R6: A resolve with `resolveHit`=0, or any cycle with `resolveValid`=0, changes no entry, raises no `misSteer` and leaves both counts unchanged.
- R7: `resolvedCount` rises by one after each hit resolve, and `misSteerCount` rises by one after each resolve that raises `misSteer`.
- R8: When a lookup and a hit resolve address the same entry in the same cycle, the lookup shows the value the entry held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupPc | input | PC_W | Address of the memory instruction being decoded |
| predHot | output | 1 | Predicted bank: 1 hot, 0 cold |
| resolveValid | input | 1 | A completed access is reported this cycle |
| resolvePc | input | PC_W | Address of the completed memory instruction |
| resolveHit | input | 1 | The line was found in one of the two banks |
| resolveHot | input | 1 | Bank that held the line: 1 hot, 0 cold |
| misSteer | output | 1 | One-cycle pulse: the stored guess was wrong |
| resolvedCount | output | CNT_W | Number of hit resolves since reset |
| misSteerCount | output | CNT_W | Number of mis-steers since reset |

## Verification
The prediction is due in the same cycle as its lookup address. The bench therefore drives `lookupPc` just after a falling edge and samples `predHot` one time unit later, before the next rising edge. The mis-steer pulse, the entry update and both counts all appear after the rising edge that takes the resolve. They are sampled at the following falling edge, before the next stimulus is driven. The same-cycle collision case samples the lookup both before and after that rising edge.

// File: rtl/bank_steer_pkg.sv
package bank_steer_pkg;

  typedef struct packed {
    logic wrEn;    // write the resolved bank into the table
    logic wrBit;   // value to write: 1 hot, 0 cold
    logic missSet; // stored guess disagreed with the actual bank
    logic cntRes;  // count one hit resolve
  } steerStrobes_t;

endpackage

// File: rtl/bank_steer_ctrl.sv
module bank_steer_ctrl
  import bank_steer_pkg::*;
(
  input  logic          resolveValid,
  input  logic          resolveHit,
  input  logic          resolveHot,
  input  logic          storedBit,
  output steerStrobes_t strobes
);

  logic hitResolve;

  always_comb begin
    hitResolve      = resolveValid && resolveHit;
    strobes.wrEn    = hitResolve;
    strobes.wrBit   = resolveHot;
    strobes.missSet = hitResolve && (storedBit != resolveHot);
    strobes.cntRes  = hitResolve;
  end

endmodule

// File: rtl/bank_steer_dp.sv
module bank_steer_dp
  import bank_steer_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 12,
  parameter int PC_LSB = 2,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  lookupPc,
  input  logic [PC_W-1:0]  resolvePc,
  input  steerStrobes_t    strobes,
  output logic             predHot,
  output logic             storedBit,
  output logic             misSteer,
  output logic [CNT_W-1:0] resolvedCount,
  output logic [CNT_W-1:0] misSteerCount
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int IDX_HI = PC_LSB + IDX_W - 1;

  logic [DEPTH-1:0] entryBits;
  logic [IDX_W-1:0] lookIdx;
  logic [IDX_W-1:0] resIdx;
  logic             unusedPcBits;

  assign lookIdx      = lookupPc[IDX_HI:PC_LSB];
  assign resIdx       = resolvePc[IDX_HI:PC_LSB];
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_HI+1], lookupPc[PC_LSB-1:0],
                          resolvePc[PC_W-1:IDX_HI+1], resolvePc[PC_LSB-1:0]};

  assign predHot   = entryBits[lookIdx];
  assign storedBit = entryBits[resIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryBits <= '1;
    end else if (strobes.wrEn) begin
      entryBits[resIdx] <= strobes.wrBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      misSteer      <= 1'b0;
      resolvedCount <= '0;
      misSteerCount <= '0;
    end else begin
      misSteer <= strobes.missSet;
      if (strobes.cntRes)  resolvedCount <= resolvedCount + 1'b1;
      if (strobes.missSet) misSteerCount <= misSteerCount + 1'b1;
    end
  end

  AST_RESET_HOT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (predHot && !misSteer && resolvedCount == '0)); // R3

  AST_TRAIN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> entryBits[$past(resIdx)] == $past(strobes.wrBit)); // R4

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    misSteer |-> $past(strobes.wrEn) && ($past(storedBit) != $past(strobes.wrBit))); // R5

  AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEn |=> (!misSteer && $stable(entryBits) && $stable(resolvedCount))); // R6

  AST_MISS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    misSteer |-> misSteerCount == $past(misSteerCount) + 1'b1); // R7

endmodule

// File: rtl/bank_steer_pred.sv
module bank_steer_pred
  import bank_steer_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 12,
  parameter int PC_LSB = 2,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  lookupPc,
  output logic             predHot,
  input  logic             resolveValid,
  input  logic [PC_W-1:0]  resolvePc,
  input  logic             resolveHit,
  input  logic             resolveHot,
  output logic             misSteer,
  output logic [CNT_W-1:0] resolvedCount,
  output logic [CNT_W-1:0] misSteerCount
);

  steerStrobes_t strobes;
  logic          storedBit;

  bank_steer_ctrl u_ctrl (
    .resolveValid (resolveValid),
    .resolveHit   (resolveHit),
    .resolveHot   (resolveHot),
    .storedBit    (storedBit),
    .strobes      (strobes)
  );

  bank_steer_dp #(
    .PC_W   (PC_W),
    .IDX_W  (IDX_W),
    .PC_LSB (PC_LSB),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .lookupPc      (lookupPc),
    .resolvePc     (resolvePc),
    .strobes       (strobes),
    .predHot       (predHot),
    .storedBit     (storedBit),
    .misSteer      (misSteer),
    .resolvedCount (resolvedCount),
    .misSteerCount (misSteerCount)
  );

endmodule

// File: tb/bank_steer_pred_tb.sv
module bank_steer_pred_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int NVEC       = 10;

  // {pc[31:0], valid, hit, hot, expected prediction, expected mis-steer next cycle}
  localparam logic [36:0] VEC [NVEC] = '{
    {32'h0000_0100, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {32'h0000_0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h0000_0100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {32'h0000_0204, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_0204, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0000_0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h0000_0204, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {32'h0000_4204, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h0000_0103, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [31:0]      lookupPc = '0;
  logic             predHot;
  logic             resolveValid = 1'b0;
  logic [31:0]      resolvePc = '0;
  logic             resolveHit = 1'b0;
  logic             resolveHot = 1'b0;
  logic             misSteer;
  logic [CNT_W-1:0] resolvedCount;
  logic [CNT_W-1:0] misSteerCount;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_steer_pred u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .lookupPc      (lookupPc),
    .predHot       (predHot),
    .resolveValid  (resolveValid),
    .resolvePc     (resolvePc),
    .resolveHit    (resolveHit),
    .resolveHot    (resolveHot),
    .misSteer      (misSteer),
    .resolvedCount (resolvedCount),
    .misSteerCount (misSteerCount)
  );

  task automatic check(input string req, input longint actual, input longint expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R3: reset state, during and after reset
    repeat (2) @(negedge clk);
    lookupPc = 32'h0000_0abc;
    #1 check("R3 pred in reset", predHot, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    lookupPc = 32'h0000_3ffc;
    #1 check("R3 pred after reset", predHot, 1);
    check("R3 misSteer", misSteer, 0);
    check("R3 resolvedCount", resolvedCount, 0);
    check("R3 misSteerCount", misSteerCount, 0);
    @(negedge clk);

    // R1 R2 R4 R5 R6: vector table
    for (int i = 0; i < NVEC; i++) begin
      lookupPc     = VEC[i][36:5];
      resolvePc    = VEC[i][36:5];
      resolveValid = VEC[i][4];
      resolveHit   = VEC[i][3];
      resolveHot   = VEC[i][2];
      #1 check($sformatf("R2/R1/R4 vec %0d pred", i), predHot, VEC[i][1]);
      @(negedge clk);
      check($sformatf("R5/R6 vec %0d misSteer", i), misSteer, VEC[i][0]);
    end
    resolveValid = 1'b0;
    resolveHit   = 1'b0;

    // R7: six hit resolves, four of them mis-steered
    check("R7 resolvedCount", resolvedCount, 6);
    check("R7 misSteerCount", misSteerCount, 4);

    // R5: pulse lasts one cycle only
    @(negedge clk);
    check("R5 pulse cleared", misSteer, 0);

    // R6: a miss in both banks leaves the entry and counts alone
    lookupPc     = 32'h0000_0100;
    resolvePc    = 32'h0000_0100;
    resolveValid = 1'b1;
    resolveHit   = 1'b0;
    resolveHot   = 1'b1;
    @(negedge clk);
    resolveValid = 1'b0;
    #1 check("R6 entry kept", predHot, 0);
    check("R6 no pulse", misSteer, 0);
    check("R6 count kept", resolvedCount, 6);

    // R8: lookup and hit resolve on one entry in the same cycle
    @(negedge clk);
    lookupPc     = 32'h0000_0800;
    resolvePc    = 32'h0000_0800;
    resolveValid = 1'b1;
    resolveHit   = 1'b1;
    resolveHot   = 1'b0;
    #1 check("R8 old value seen", predHot, 1);
    @(negedge clk);
    resolveValid = 1'b0;
    #1 check("R8 new value next cycle", predHot, 0);
    check("R8 R5 pulse", misSteer, 1);
    check("R7 count after collision", misSteerCount, 5);

    // R1: an address differing above bit 13 aliases to the same entry
    lookupPc = 32'h0001_0800;
    #1 check("R1 alias high bits", predHot, 0);
    lookupPc = 32'h0000_0804;
    #1 check("R1 neighbour entry", predHot, 1);

    finished = 1'b1;
    finish_run();
  end

endmodule